// File: doc/BRIEF.md
# Per-Input Circular Page Allocator

This block manages how a set of signal inputs share one page-addressed memory. Each input gets its own slice of the page space, given by a first page and a length in pages. Inside that slice the input writes pages in a ring. When the last page of the slice has been written, the next write goes back to the first page. An upstream packer reports each finished page together with its sample sequence number (SSN). The allocator answers one cycle later with the memory page that the data belongs in.

Each input has a record switch. Clearing the switch freezes the ring. Further finished pages for that input are then ignored, and the data already held stays where it is. Setting the switch again resumes at the next ring slot. For every input the block keeps three status values: how many fresh pages the ring holds, which page was written last, and the SSN of that last page. These can be read through a status selector.

Allocations are checked against the total page space of 2^PAGE_W pages. With the default of 21 bits this is 2M pages of 8 KiB, or 16 GiB. A request that would run past the end of the page space is refused.

Top module: `page_ring_alloc`

## Requirements
- R1: After reset every input has start 0, count 0, recording off, fresh count 0, last page 0 and last SSN 0. `cfg_err` and `wr_valid` are 0.
- R2: An allocation with `cfg_start + cfg_count <= 2^PAGE_W` is accepted and clears `cfg_err`. A larger one is rejected: it sets `cfg_err` and leaves that input unchanged.
- R3: A `page_done` for an input that is recording and has a nonzero count gives `wr_valid`=1 on the next cycle. `wr_sel` then equals that input and `wr_page` equals start plus the ring offset. The offset begins at 0 and steps by 1 per written page.
- R4: After count pages the offset returns to 0, so the write address wraps to the start page.
- R5: The fresh count rises by 1 per written page and saturates at the allocated count.
- R6: After each written page, the status shows that page's address as the last page and its SSN as the last SSN.
- R7: With recording off, `page_done` for that input produces no `wr_valid` and changes none of its status. Turning recording on again resumes at the saved offset and keeps the fresh count.
- R8: An input with count 0 writes nothing, even with recording on, and its `stat_recording` reads 0.
- R9: A page on one input never changes the status of any other input.
- R10: An accepted allocation stops recording for that input and clears its offset, fresh count, last page and last SSN.
- R11: When an allocation for an input comes in the same cycle as a `page_done` or a record command for that same input, the allocation wins. The page is dropped and recording stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Allocation write strobe |
| cfg_sel | input | SEL_W | Input addressed by the allocation |
| cfg_start | input | PAGE_W | First page of the ring |
| cfg_count | input | PAGE_W+1 | Ring length in pages (0 = no buffer) |
| cfg_err | output | 1 | Last allocation was rejected |
| rec_we | input | 1 | Record control strobe |
| rec_sel | input | SEL_W | Input addressed by the record control |
| rec_on | input | 1 | 1 = record, 0 = freeze |
| page_done | input | 1 | A page has been completed |
| page_sel | input | SEL_W | Input that completed the page |
| page_ssn | input | SSN_W | SSN of the completed page |
| wr_valid | output | 1 | Write address valid |
| wr_sel | output | SEL_W | Input of the write |
| wr_page | output | PAGE_W | Memory page to write |
| stat_sel | input | SEL_W | Input whose status is shown |
| stat_start | output | PAGE_W | Allocated start page |
| stat_count | output | PAGE_W+1 | Allocated page count |
| stat_recording | output | 1 | Recording and count nonzero |
| stat_fresh | output | PAGE_W+1 | Fresh pages held |
| stat_last_page | output | PAGE_W | Page written last |
| stat_last_ssn | output | SSN_W | SSN of the page written last |

## Verification
The bench runs with a 16-page space. It sweeps every start page against every length from zero to one past the legal limit. This shows where allocations stop being accepted and where they start being refused.

Each accepted ring is driven with more than two laps of pages. That separates a correct wrap from an early or late one, and a saturating fresh count from one that keeps counting or rolls over. During the sweep a second input is left with a fixed ring, and it is re-read to show that it stays untouched.

Directed sequences cover freeze and resume, reallocation while recording, and a same-cycle collision between an allocation and a page. The freeze-and-resume test tells a ring that continues from its saved slot apart from one that restarts.

// File: rtl/page_ring_alloc.sv
module page_ring_alloc #(
  parameter int N_IN   = 4,
  parameter int PAGE_W = 21,
  parameter int SSN_W  = 64,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CNT_W = PAGE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [PAGE_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             cfg_err,
  input  logic             rec_we,
  input  logic [SEL_W-1:0] rec_sel,
  input  logic             rec_on,
  input  logic             page_done,
  input  logic [SEL_W-1:0] page_sel,
  input  logic [SSN_W-1:0] page_ssn,
  output logic             wr_valid,
  output logic [SEL_W-1:0] wr_sel,
  output logic [PAGE_W-1:0] wr_page,
  input  logic [SEL_W-1:0] stat_sel,
  output logic [PAGE_W-1:0] stat_start,
  output logic [CNT_W-1:0] stat_count,
  output logic             stat_recording,
  output logic [CNT_W-1:0] stat_fresh,
  output logic [PAGE_W-1:0] stat_last_page,
  output logic [SSN_W-1:0] stat_last_ssn
);
  localparam logic [PAGE_W+1:0] TOTAL = (PAGE_W+2)'(1) << PAGE_W;

  logic [PAGE_W-1:0] start_q [N_IN];
  logic [CNT_W-1:0]  count_q [N_IN];
  logic [PAGE_W-1:0] ptr_q   [N_IN];
  logic [CNT_W-1:0]  fresh_q [N_IN];
  logic [PAGE_W-1:0] last_q  [N_IN];
  logic [SSN_W-1:0]  ssn_q   [N_IN];
  logic [N_IN-1:0]   rec_q;

  logic              cfg_ok;
  logic [N_IN-1:0]   cfg_hit, rec_hit, pg_go;

  assign cfg_ok = ({2'b00, cfg_start} + {1'b0, cfg_count}) <= TOTAL;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      cfg_hit[i] = cfg_we && cfg_ok && (cfg_sel == SEL_W'(i));
      rec_hit[i] = rec_we && (rec_sel == SEL_W'(i));
      pg_go[i]   = page_done && (page_sel == SEL_W'(i)) && rec_q[i] &&
                   (count_q[i] != '0) && !cfg_hit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) begin
        start_q[i] <= '0;
        count_q[i] <= '0;
        ptr_q[i]   <= '0;
        fresh_q[i] <= '0;
        last_q[i]  <= '0;
        ssn_q[i]   <= '0;
      end
      rec_q    <= '0;
      cfg_err  <= 1'b0;
      wr_valid <= 1'b0;
      wr_sel   <= '0;
      wr_page  <= '0;
    end else begin
      if (cfg_we) cfg_err <= !cfg_ok;
      wr_valid <= |pg_go;
      if (|pg_go) begin
        wr_sel  <= page_sel;
        wr_page <= start_q[page_sel] + ptr_q[page_sel];
      end
      for (int i = 0; i < N_IN; i++) begin
        if (cfg_hit[i]) begin
          start_q[i] <= cfg_start;
          count_q[i] <= cfg_count;
          rec_q[i]   <= 1'b0;
          ptr_q[i]   <= '0;
          fresh_q[i] <= '0;
          last_q[i]  <= '0;
          ssn_q[i]   <= '0;
        end else begin
          if (pg_go[i]) begin
            ptr_q[i]   <= ({1'b0, ptr_q[i]} + 1'b1 == count_q[i]) ? '0 : ptr_q[i] + 1'b1;
            fresh_q[i] <= (fresh_q[i] == count_q[i]) ? fresh_q[i] : fresh_q[i] + 1'b1;
            last_q[i]  <= start_q[i] + ptr_q[i];
            ssn_q[i]   <= page_ssn;
          end
          if (rec_hit[i]) rec_q[i] <= rec_on;
        end
      end
    end
  end

  assign stat_start     = start_q[stat_sel];
  assign stat_count     = count_q[stat_sel];
  assign stat_recording = rec_q[stat_sel] && (count_q[stat_sel] != '0);
  assign stat_fresh     = fresh_q[stat_sel];
  assign stat_last_page = last_q[stat_sel];
  assign stat_last_ssn  = ssn_q[stat_sel];
endmodule

module page_ring_alloc_chk #(
  parameter int PAGE_W = 21,
  parameter int SEL_W  = 2,
  localparam int CNT_W = PAGE_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_err,
  input logic              page_done,
  input logic [SEL_W-1:0]  page_sel,
  input logic              wr_valid,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [PAGE_W-1:0] stat_start,
  input logic [CNT_W-1:0]  stat_count,
  input logic [CNT_W-1:0]  stat_fresh,
  input logic [PAGE_W-1:0] stat_last_page
);
  // R5
  fresh_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fresh <= stat_count);
  // R3
  wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_done |=> !wr_valid);
  // R3
  wr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> (!wr_valid || wr_sel == $past(page_sel)));
  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_we));
  // R4
  last_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fresh != '0 |-> (stat_last_page >= stat_start &&
      ({1'b0, stat_last_page} - {1'b0, stat_start}) < stat_count));
endmodule

bind page_ring_alloc page_ring_alloc_chk #(.PAGE_W(PAGE_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_err(cfg_err),
  .page_done(page_done), .page_sel(page_sel), .wr_valid(wr_valid), .wr_sel(wr_sel),
  .stat_start(stat_start), .stat_count(stat_count), .stat_fresh(stat_fresh),
  .stat_last_page(stat_last_page));

// File: tb/page_ring_alloc_tb.sv
`timescale 1ns/1ps
module page_ring_alloc_tb;
  localparam int N = 2, PW = 4, SW = 16, CW = PW + 1, SL = 1, TOT = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, rec_we = 0, rec_on = 0, page_done = 0;
  logic [SL-1:0] cfg_sel = 0, rec_sel = 0, page_sel = 0, stat_sel = 0;
  logic [PW-1:0] cfg_start = 0;
  logic [CW-1:0] cfg_count = 0;
  logic [SW-1:0] page_ssn = 0;
  logic cfg_err, wr_valid, stat_recording;
  logic [SL-1:0] wr_sel;
  logic [PW-1:0] wr_page, stat_start, stat_last_page;
  logic [CW-1:0] stat_count, stat_fresh;
  logic [SW-1:0] stat_last_ssn;

  int n_chk = 0, n_fail = 0;
  int e_start[N], e_cnt[N], e_ptr[N], e_fresh[N], e_last[N], e_ssn[N], e_rec[N];

  page_ring_alloc #(.N_IN(N), .PAGE_W(PW), .SSN_W(SW)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_stat(input int i, input string tag);
    stat_sel = SL'(i);
    #1;
    chk(stat_start == PW'(e_start[i]), {tag, " start"}, stat_start, e_start[i]);
    chk(stat_count == CW'(e_cnt[i]), {tag, " count"}, stat_count, e_cnt[i]);
    chk(stat_recording == (e_rec[i] != 0 && e_cnt[i] != 0), {tag, " recording"},
        stat_recording, (e_rec[i] != 0 && e_cnt[i] != 0));
    chk(stat_fresh == CW'(e_fresh[i]), {tag, " fresh"}, stat_fresh, e_fresh[i]);
    chk(stat_last_page == PW'(e_last[i]), {tag, " last_page"}, stat_last_page, e_last[i]);
    chk(stat_last_ssn == SW'(e_ssn[i]), {tag, " last_ssn"}, stat_last_ssn, e_ssn[i]);
  endtask

  function automatic void mdl_cfg(input int i, input int s, input int c);
    e_start[i] = s; e_cnt[i] = c; e_rec[i] = 0;
    e_ptr[i] = 0; e_fresh[i] = 0; e_last[i] = 0; e_ssn[i] = 0;
  endfunction

  task automatic do_cfg(input int i, input int s, input int c);
    bit ok = (s + c) <= TOT;
    @(negedge clk);
    cfg_we = 1; cfg_sel = SL'(i); cfg_start = PW'(s); cfg_count = CW'(c);
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_err == !ok, "R2 cfg_err", cfg_err, !ok);
    if (ok) mdl_cfg(i, s, c);
  endtask

  task automatic do_rec(input int i, input bit on);
    @(negedge clk);
    rec_we = 1; rec_sel = SL'(i); rec_on = on;
    @(negedge clk);
    rec_we = 0;
    e_rec[i] = on;
  endtask

  task automatic do_page(input int i, input int ssn, input string tag);
    bit go = e_rec[i] != 0 && e_cnt[i] != 0;
    int ep = e_start[i] + e_ptr[i];
    @(negedge clk);
    page_done = 1; page_sel = SL'(i); page_ssn = SW'(ssn);
    @(negedge clk);
    page_done = 0;
    chk(wr_valid == go, {tag, " wr_valid"}, wr_valid, go);
    if (go) begin
      chk(wr_page == PW'(ep), {tag, " wr_page"}, wr_page, ep);
      chk(wr_sel == SL'(i), {tag, " wr_sel"}, wr_sel, i);
      e_last[i] = ep; e_ssn[i] = ssn;
      e_ptr[i] = (e_ptr[i] + 1 == e_cnt[i]) ? 0 : e_ptr[i] + 1;
      if (e_fresh[i] < e_cnt[i]) e_fresh[i]++;
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mdl_cfg(i, 0, 0);
    #35 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    for (int i = 0; i < N; i++) chk_stat(i, "R1");

    // R8 zero count records nothing
    do_rec(0, 1);
    do_page(0, 5, "R8");
    chk_stat(0, "R8");

    // Second input kept fixed for the independence check (R9)
    do_cfg(1, 10, 3);
    do_rec(1, 1);
    do_page(1, 77, "R3 in1");

    // R2 R3 R4 R5 R6 sweep over all starts and lengths
    for (int s = 0; s < TOT; s++) begin
      for (int c = 0; c <= 17 - s; c++) begin
        do_cfg(0, s, c);
        chk_stat(0, "R2 R10");
        do_rec(0, 1);
        for (int k = 0; k < 2 * c + 3; k++) begin
          do_page(0, s * 256 + c * 8 + k, "R3 R4");
          chk_stat(0, "R5 R6");
        end
        chk_stat(1, "R9");
      end
    end

    // R7 freeze and resume
    do_cfg(0, 2, 5);
    do_rec(0, 1);
    for (int k = 0; k < 3; k++) do_page(0, 100 + k, "R7 pre");
    do_rec(0, 0);
    for (int k = 0; k < 4; k++) do_page(0, 200 + k, "R7 frozen");
    chk_stat(0, "R7 frozen");
    do_rec(0, 1);
    for (int k = 0; k < 4; k++) do_page(0, 300 + k, "R7 resumed");
    chk_stat(0, "R7 resumed");

    // R2 rejected allocation leaves input unchanged, then clears on accept
    do_cfg(0, 12, 6);
    chk_stat(0, "R2 reject");
    do_page(0, 400, "R2 still recording");
    do_cfg(0, 0, 16);
    chk_stat(0, "R2 accept");

    // R10 reallocation while recording stops it
    do_rec(0, 1);
    do_page(0, 500, "R10 pre");
    do_cfg(0, 4, 4);
    chk_stat(0, "R10");
    do_page(0, 501, "R10 stopped");

    // R11 allocation beats page and record on the same input
    do_rec(0, 1);
    do_page(0, 600, "R11 pre");
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_start = 8; cfg_count = 2;
    page_done = 1; page_sel = 0; page_ssn = 601;
    rec_we = 1; rec_sel = 0; rec_on = 1;
    @(negedge clk);
    cfg_we = 0; page_done = 0; rec_we = 0;
    mdl_cfg(0, 8, 2);
    chk(wr_valid == 0, "R11 wr_valid", wr_valid, 0);
    chk_stat(0, "R11");

    // R9 final check on the second input
    chk_stat(1, "R9 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule